// File: doc/BRIEF.md
# Operand-Isolated Accumulator ALU

This block is an 8-bit accumulator datapath tuned for low switching activity. A pair of operand registers stands in front of the combinational ALU. Both load on the same clock edge, and only when an operation is issued; between issues the ALU inputs do not move, however much the source buses toggle. The capture enable stands in for a gated clock, and the operand registers double as a pipeline stage. Each operation therefore writes its result one cycle after its operands are taken.

Each issued operation selects its two operands from the A and B source buses or from the register file. The register file holds the accumulator and two general registers. The operation names a destination among those three registers, or no destination at all, which updates the flags only. The result of every operation appears on the result bus. A carry flag and a zero flag record the outcome of the last operation. The next operation can read the register the previous one is still writing, because the pending result is forwarded into the operand registers.

Top module: `gated_alu_core`

## Requirements
- R1: A synchronous active-high reset clears the result bus, the accumulator, both general registers and the carry and zero flags to zero on the next clock edge.
- R2: Without issue, the operand registers do not load. Toggling the buses, the opcode or the selects then leaves the result, the accumulator and the flags unchanged.
- R3: An operation issued at clock edge E captures its operands at E and updates the result, the destination and the flags at edge E+1, not earlier.
- R4: Opcode 000 (ADD) produces A+B and opcode 110 (ADC) produces A+B+carry; the new carry is the adder carry-out.
- R5: Opcode 001 (SUB) produces A-B and opcode 111 (SBC) produces A-B-(1-carry); the new carry is set when no borrow occurs.
- R6: Opcode 010 is AND, 011 is OR, 100 is XOR and 101 passes B; each clears the carry flag.
- R7: After every operation the zero flag is set exactly when the 8-bit result is zero.
- R8: Destination code 00 writes the accumulator, 01 the first general register, 10 the second, and 11 nothing; the result bus shows the result for every code.
- R9: Operand select code 00 takes the operation's own source bus, 01 the accumulator, 10 the first general register and 11 the second, for both operands.
- R10: An operation issued in the cycle right after another reads the result of that earlier operation when it selects the register the earlier one writes; ADC and SBC use the carry that the earlier operation produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Issue strobe; captures operands on this edge |
| opcode | input | 3 | Operation code |
| aSel | input | 2 | Source of operand A |
| bSel | input | 2 | Source of operand B |
| dstSel | input | 2 | Destination of the result |
| busA | input | 8 | Source bus A |
| busB | input | 8 | Source bus B |
| resultOut | output | 8 | Result of the last operation |
| accOut | output | 8 | Accumulator |
| carryOut | output | 1 | Carry flag |
| zeroOut | output | 1 | Zero flag |

## Verification
Writeback and operand capture can fall on the same edge. Operation one writes its destination while operation two captures operands from that same register. For ADC and SBC, operation two also relies on the carry that operation one writes. The bench provokes this by issuing on consecutive cycles with register operands: accumulator plus accumulator, a general register read just after it is written, and a carry chain. It judges the outcomes against a sequential model of the register file, in which each operation sees every earlier result.

// File: rtl/gated_alu_pkg.sv
package gated_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSB = 3'd5,
    OP_ADC   = 3'd6,
    OP_SBC   = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_BUS = 2'd0,
    SRC_ACC = 2'd1,
    SRC_R0  = 2'd2,
    SRC_R1  = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    DST_ACC  = 2'd0,
    DST_R0   = 2'd1,
    DST_R1   = 2'd2,
    DST_NONE = 2'd3
  } dstSel_e;

  typedef struct packed {
    logic capture;
    logic execute;
    logic wrAcc;
    logic wrR0;
    logic wrR1;
    logic fwdA;
    logic fwdB;
  } ctrlStrobes_t;

endpackage

// File: rtl/gated_alu_unit.sv
module gated_alu_unit
  import gated_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOp_e            op,
  input  logic              carryIn,
  output logic [DATA_W-1:0] res,
  output logic              carryNext
);

  logic [DATA_W-1:0] bAdd;
  logic              cinAdd;
  logic [DATA_W:0]   sum;

  always_comb begin
    bAdd = ((op == OP_SUB) || (op == OP_SBC)) ? ~opB : opB;
    case (op)
      OP_ADD:  cinAdd = 1'b0;
      OP_SUB:  cinAdd = 1'b1;
      default: cinAdd = carryIn;
    endcase
    sum = {1'b0, opA} + {1'b0, bAdd} + {{DATA_W{1'b0}}, cinAdd};

    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBC: begin
        res       = sum[DATA_W-1:0];
        carryNext = sum[DATA_W];
      end
      OP_AND: begin
        res       = opA & opB;
        carryNext = 1'b0;
      end
      OP_OR: begin
        res       = opA | opB;
        carryNext = 1'b0;
      end
      OP_XOR: begin
        res       = opA ^ opB;
        carryNext = 1'b0;
      end
      default: begin
        res       = opB;
        carryNext = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gated_alu_ctrl.sv
module gated_alu_ctrl
  import gated_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  srcSel_e      aSel,
  input  srcSel_e      bSel,
  input  dstSel_e      dstSel,
  output ctrlStrobes_t strb
);

  logic    execValid;
  dstSel_e execDst;

  // one pipeline stage of control: the issued op executes next cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      execValid <= 1'b0;
      execDst   <= DST_NONE;
    end else begin
      execValid <= issue;
      if (issue) execDst <= dstSel;
    end
  end

  function automatic logic pendingHit(input srcSel_e sel);
    pendingHit = execValid &&
                 (((sel == SRC_ACC) && (execDst == DST_ACC)) ||
                  ((sel == SRC_R0)  && (execDst == DST_R0))  ||
                  ((sel == SRC_R1)  && (execDst == DST_R1)));
  endfunction

  always_comb begin
    strb.capture = issue;
    strb.execute = execValid;
    strb.wrAcc   = execValid && (execDst == DST_ACC);
    strb.wrR0    = execValid && (execDst == DST_R0);
    strb.wrR1    = execValid && (execDst == DST_R1);
    strb.fwdA    = issue && pendingHit(aSel);
    strb.fwdB    = issue && pendingHit(bSel);
  end

endmodule

// File: rtl/gated_alu_dp.sv
module gated_alu_dp
  import gated_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  aluOp_e            opcode,
  input  srcSel_e           aSel,
  input  srcSel_e           bSel,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic              zeroOut
);

  logic [DATA_W-1:0] opAQ, opBQ;
  aluOp_e            opQ;
  logic [DATA_W-1:0] accQ, r0Q, r1Q, resultQ;
  logic              carryQ, zeroQ;
  logic [DATA_W-1:0] aluRes;
  logic              aluCarry;
  logic [DATA_W-1:0] aIn, bIn;

  function automatic logic [DATA_W-1:0] pickSrc(input srcSel_e sel,
                                                input logic [DATA_W-1:0] bus,
                                                input logic [DATA_W-1:0] acc,
                                                input logic [DATA_W-1:0] r0,
                                                input logic [DATA_W-1:0] r1);
    case (sel)
      SRC_BUS: pickSrc = bus;
      SRC_ACC: pickSrc = acc;
      SRC_R0:  pickSrc = r0;
      default: pickSrc = r1;
    endcase
  endfunction

  always_comb begin
    aIn = strb.fwdA ? aluRes : pickSrc(aSel, busA, accQ, r0Q, r1Q);
    bIn = strb.fwdB ? aluRes : pickSrc(bSel, busB, accQ, r0Q, r1Q);
  end

  // operand isolation: loads jointly, only on issue (clock-enable in place of a gated clock)
  always_ff @(posedge clk) begin
    if (rst) begin
      opAQ <= '0;
      opBQ <= '0;
      opQ  <= OP_ADD;
    end else if (strb.capture) begin
      opAQ <= aIn;
      opBQ <= bIn;
      opQ  <= opcode;
    end
  end

  gated_alu_unit #(.DATA_W(DATA_W)) u_alu (
    .opA      (opAQ),
    .opB      (opBQ),
    .op       (opQ),
    .carryIn  (carryQ),
    .res      (aluRes),
    .carryNext(aluCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      accQ    <= '0;
      r0Q     <= '0;
      r1Q     <= '0;
      carryQ  <= 1'b0;
      zeroQ   <= 1'b0;
    end else if (strb.execute) begin
      resultQ <= aluRes;
      carryQ  <= aluCarry;
      zeroQ   <= (aluRes == '0);
      if (strb.wrAcc) accQ <= aluRes;
      if (strb.wrR0)  r0Q  <= aluRes;
      if (strb.wrR1)  r1Q  <= aluRes;
    end
  end

  assign resultOut = resultQ;
  assign accOut    = accQ;
  assign carryOut  = carryQ;
  assign zeroOut   = zeroQ;

endmodule

// File: rtl/gated_alu_core.sv
module gated_alu_core
  import gated_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [2:0]        opcode,
  input  logic [1:0]        aSel,
  input  logic [1:0]        bSel,
  input  logic [1:0]        dstSel,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] accOut,
  output logic              carryOut,
  output logic              zeroOut
);

  ctrlStrobes_t strb;

  gated_alu_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .issue (issue),
    .aSel  (srcSel_e'(aSel)),
    .bSel  (srcSel_e'(bSel)),
    .dstSel(dstSel_e'(dstSel)),
    .strb  (strb)
  );

  gated_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .opcode   (aluOp_e'(opcode)),
    .aSel     (srcSel_e'(aSel)),
    .bSel     (srcSel_e'(bSel)),
    .busA     (busA),
    .busB     (busB),
    .resultOut(resultOut),
    .accOut   (accOut),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

endmodule

// File: rtl/gated_alu_core_checker.sv
module gated_alu_core_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              issue,
  input logic [2:0]        opcode,
  input logic [1:0]        dstSel,
  input logic [DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0] accOut,
  input logic              carryOut,
  input logic              zeroOut
);

  // R1: reset clears the visible state on the next edge
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (accOut == '0) && (resultOut == '0) && !carryOut && !zeroOut);

  // R2: no issue, so nothing visible changes two edges later
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !issue |=> ##1 ($stable(accOut) && $stable(resultOut) &&
                    $stable(carryOut) && $stable(zeroOut)));

  // R6: logic and pass operations clear carry
  p_logic_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (issue && (opcode inside {3'd2, 3'd3, 3'd4, 3'd5})) |=> ##1 !carryOut);

  // R7: zero flag tracks the result bus after an operation
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    issue |=> ##1 (zeroOut == (resultOut == '0)));

  // R8: discard destination leaves the accumulator untouched
  p_dst_none_r8: assert property (@(posedge clk) disable iff (rst)
    (issue && (dstSel == 2'd3)) |=> ##1 $stable(accOut));

  // R8: accumulator destination copies the result
  p_dst_acc_r8: assert property (@(posedge clk) disable iff (rst)
    (issue && (dstSel == 2'd0)) |=> ##1 (accOut == resultOut));

endmodule

bind gated_alu_core gated_alu_core_checker #(.DATA_W(DATA_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .issue    (issue),
  .opcode   (opcode),
  .dstSel   (dstSel),
  .resultOut(resultOut),
  .accOut   (accOut),
  .carryOut (carryOut),
  .zeroOut  (zeroOut)
);

// File: tb/gated_alu_core_bench.sv
module gated_alu_core_bench;

  localparam int CLK_PERIOD    = 10;
  localparam int WATCHDOG_CYC  = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue = 1'b0;
  logic [2:0] opcode = 3'd0;
  logic [1:0] aSel = 2'd0, bSel = 2'd0, dstSel = 2'd0;
  logic [7:0] busA = 8'h00, busB = 8'h00;
  logic [7:0] resultOut, accOut;
  logic       carryOut, zeroOut;

  gated_alu_core u_gated_alu_core (
    .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
    .aSel(aSel), .bSel(bSel), .dstSel(dstSel), .busA(busA), .busB(busB),
    .resultOut(resultOut), .accOut(accOut), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [7:0] res;
    logic [7:0] acc;
    logic       c;
    logic       z;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // architectural model, sequential program order
  logic [7:0] mAcc = 8'h00, mR0 = 8'h00, mR1 = 8'h00;
  logic       mC = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [7:0] pickSrc(input logic [1:0] sel, input logic [7:0] bus);
    case (sel)
      2'd0:    pickSrc = bus;
      2'd1:    pickSrc = mAcc;
      2'd2:    pickSrc = mR0;
      default: pickSrc = mR1;
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [1:0] sa, input logic [1:0] sb,
                      input logic [1:0] d, input logic [7:0] a, input logic [7:0] b,
                      input string tag);
    int x, y, r, bw;
    logic c;
    expItem_t it;
    @(negedge clk);
    opcode = op; aSel = sa; bSel = sb; dstSel = d; busA = a; busB = b; issue = 1'b1;
    x = int'(pickSrc(sa, a));
    y = int'(pickSrc(sb, b));
    c = 1'b0;
    case (op)
      3'd0: begin r = x + y;      c = (r > 255); end
      3'd6: begin r = x + y + int'(mC); c = (r > 255); end
      3'd1: begin r = x - y;      c = (x >= y); end
      3'd7: begin bw = 1 - int'(mC); r = x - y - bw; c = (x >= y + bw); end
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      default: r = y;
    endcase
    r = r & 255;
    case (d)
      2'd0: mAcc = r[7:0];
      2'd1: mR0  = r[7:0];
      2'd2: mR1  = r[7:0];
      default: ;
    endcase
    mC = c;
    it.due = cyc + 2; it.res = r[7:0]; it.acc = mAcc; it.c = c; it.z = (r == 0); it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) begin
      @(negedge clk);
      issue = 1'b0;
      busA = busA + 8'h11; busB = busB ^ 8'h5A; opcode = opcode + 3'd1;
      aSel = aSel + 2'd1; dstSel = dstSel + 2'd1;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].due == cyc) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, "result", {1'b0, resultOut}, {1'b0, e.res});
        check(e.tag, "acc",    {1'b0, accOut},    {1'b0, e.acc});
        check(e.tag, "flags",  {7'd0, carryOut, zeroOut}, {7'd0, e.c, e.z});
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    fails++; checks++;
    $display("FAIL R3 watchdog: actual cycle %0d expected completion earlier", cyc);
    finishRun();
  end

  initial begin
    logic [7:0] prevAcc, snapRes, snapAcc;
    logic       snapC, snapZ;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset result", {1'b0, resultOut}, 9'h000);
    check("R1", "reset acc",    {1'b0, accOut},    9'h000);
    check("R1", "reset flags",  {7'd0, carryOut, zeroOut}, 9'h000);
    rst = 1'b0;

    // R4 / R9 / R7 basic arithmetic from buses
    doOp(3'd0, 2'd0, 2'd0, 2'd0, 8'h3C, 8'h05, "R4 add");
    doOp(3'd0, 2'd0, 2'd0, 2'd0, 8'hF0, 8'h20, "R4 add carry");
    doOp(3'd6, 2'd1, 2'd0, 2'd0, 8'h00, 8'h01, "R4 adc");
    // R5 subtraction, borrow and equal
    doOp(3'd1, 2'd0, 2'd0, 2'd1, 8'h10, 8'h20, "R5 sub borrow");
    doOp(3'd1, 2'd0, 2'd0, 2'd2, 8'h55, 8'h55, "R5 R7 sub zero");
    doOp(3'd7, 2'd0, 2'd0, 2'd0, 8'h40, 8'h10, "R5 sbc");
    doOp(3'd1, 2'd0, 2'd0, 2'd3, 8'h00, 8'h01, "R5 borrow set");
    doOp(3'd7, 2'd0, 2'd0, 2'd0, 8'h40, 8'h10, "R5 sbc borrow-in");
    // R6 logic and pass
    doOp(3'd2, 2'd0, 2'd0, 2'd0, 8'hF0, 8'h3C, "R6 and");
    doOp(3'd3, 2'd0, 2'd0, 2'd0, 8'hF0, 8'h0F, "R6 or");
    doOp(3'd4, 2'd0, 2'd0, 2'd0, 8'hAA, 8'hAA, "R6 R7 xor zero");
    doOp(3'd5, 2'd0, 2'd0, 2'd0, 8'h00, 8'h99, "R6 passb");
    // R8 / R9 register destinations and operand selects
    doOp(3'd5, 2'd0, 2'd2, 2'd3, 8'h00, 8'h00, "R8 R9 read r0");
    doOp(3'd0, 2'd2, 2'd1, 2'd2, 8'h00, 8'h00, "R9 r0 plus acc");
    doOp(3'd5, 2'd0, 2'd3, 2'd3, 8'h00, 8'h00, "R8 R9 read r1");
    // R10 back-to-back forwarding
    doOp(3'd0, 2'd0, 2'd0, 2'd0, 8'h11, 8'h22, "R10 seed");
    doOp(3'd0, 2'd1, 2'd1, 2'd2, 8'h00, 8'h00, "R10 acc+acc");
    doOp(3'd5, 2'd0, 2'd3, 2'd3, 8'h00, 8'h00, "R10 read r1");
    doOp(3'd0, 2'd0, 2'd0, 2'd1, 8'hFF, 8'h02, "R10 carry gen");
    doOp(3'd6, 2'd2, 2'd2, 2'd0, 8'h00, 8'h00, "R10 adc chain");
    doOp(3'd1, 2'd1, 2'd0, 2'd1, 8'h00, 8'h03, "R10 sub acc");
    idleCycles(3);

    // R3: destination not updated at the capture edge
    prevAcc = accOut;
    doOp(3'd0, 2'd0, 2'd0, 2'd0, prevAcc ^ 8'h40, 8'h00, "R3 timing");
    @(negedge clk); issue = 1'b0;
    check("R3", "acc before writeback", {1'b0, accOut}, {1'b0, prevAcc});
    idleCycles(3);

    // R2: bus and opcode activity without issue changes nothing
    snapRes = resultOut; snapAcc = accOut; snapC = carryOut; snapZ = zeroOut;
    idleCycles(6);
    check("R2", "idle result", {1'b0, resultOut}, {1'b0, snapRes});
    check("R2", "idle acc",    {1'b0, accOut},    {1'b0, snapAcc});
    check("R2", "idle flags",  {7'd0, carryOut, zeroOut}, {7'd0, snapC, snapZ});
    check("R2", "acc vs model", {1'b0, accOut}, {1'b0, mAcc});

    // R1: reset in mid-run clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "mid reset acc",   {1'b0, accOut},    9'h000);
    check("R1", "mid reset result", {1'b0, resultOut}, 9'h000);
    check("R1", "mid reset flags", {7'd0, carryOut, zeroOut}, 9'h000);
    rst = 1'b0;
    mAcc = 8'h00; mR0 = 8'h00; mR1 = 8'h00; mC = 1'b0;
    doOp(3'd3, 2'd2, 2'd3, 2'd3, 8'h00, 8'h00, "R1 regs cleared");
    idleCycles(4);

    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3 pending items: actual %0d expected 0", expQ.size());
    end
    finishRun();
  end

endmodule